// File: doc/BRIEF.md
# Frame-Synchronous Line-Toggled Bias Pulse Generator

This block produces a single level output for a sensor's readout bias. Within every frame it counts lines, one per horizontal sync period, and at a programmed line it drives the output to a programmed level. Once switched, the output keeps that level through the rest of the frame and into the next one, until a later toggle point changes it.

Software supplies an 11-bit toggle line and a 1-bit polarity through a plain write port. A write lands in a shadow register pair and has no effect on the running frame. The pair is copied into the active registers when a falling edge of vertical sync is detected, so every setting applies to a whole frame. Both sync inputs are asynchronous to the pixel clock. They pass through a synchronizer and a falling-edge detector before they are used.

Top module: `bias_pulse_gen`

## Requirements
- R1: After reset `bias_o` is low, and it stays low through frames that follow without any register write.
- R2: A write (`wr_en_i` high for one clock) changes only the shadow pair, so `bias_o` does not change for the rest of the frame in which it occurs.
- R3: On a detected VD falling edge the shadow toggle and polarity are copied to the active pair and apply from that frame on.
- R4: The line counter is cleared by a VD falling edge and incremented by each HD falling edge.
- R5: With active toggle 2 and polarity 1 (1 = high level, 0 = low level), `bias_o` goes high after the second HD falling edge of the frame, and not after the first.
- R6: After a later update to toggle 3 and polarity 0, `bias_o` goes low after the third HD falling edge, and not after the second.
- R7: Before the toggle point of a frame, `bias_o` keeps the level it had at the end of the previous frame.
- R8: When VD and HD fall in the same clock, the VD edge wins: the counter is cleared to 0 and that HD edge is not counted.
- R9: When several writes occur in one frame, only the last one before the VD falling edge is applied.
- R10: A toggle value larger than the number of HD edges in a frame leaves `bias_o` unchanged for that frame.
- R11: A toggle value of 0 switches `bias_o` to the polarity level right after the VD falling edge, before any HD edge.
- R12: With two synchronizer stages, `bias_o` changes on the fourth rising clock edge after the HD pin falls on the line that reaches the toggle value, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd_i | input | 1 | Vertical sync; a falling edge starts a frame |
| hd_i | input | 1 | Horizontal sync; a falling edge ends one line period |
| wr_en_i | input | 1 | Write strobe for the shadow pair |
| wr_toggle_i | input | 11 | Toggle line to be written |
| wr_pol_i | input | 1 | Polarity to be written (1 high, 0 low) |
| bias_o | output | 1 | Bias pulse output |

## Verification
On every cycle the assertions check the local rules. The counter clears on a frame edge, steps once per line edge and holds otherwise. The active registers change only at a frame edge, and then take the shadow values. The output holds unless the count equals the active toggle, and when it does equal it the output takes the active polarity. The bench's scenarios are needed to show the frame-level effects: the two-step program-then-switch sequence, the last-write-wins rule, the VD-over-HD priority, toggle values out of range and at zero, and the exact pin-to-output latency.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } level_e;

   function automatic int unsigned ctr_max(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/bpg_edge_det.sv
module bpg_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall_o
);
   // pipe[0..STAGES-1] synchronizer, pipe[STAGES] previous-value flop
   logic [STAGES:0] pipe;

   genvar gi;
   generate
      for (gi = 0; gi <= STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= 1'b0;
               else        pipe[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[gi] <= 1'b0;
               else        pipe[gi] <= pipe[gi-1];
            end
         end
      end
   endgenerate

   assign fall_o = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/bpg_frame_regs.sv
module bpg_frame_regs
   import bpg_pkg::*;
#(
   parameter int TOG_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TOG_W-1:0] wr_tog,
   input  level_e           wr_pol,
   input  logic             load,
   output logic [TOG_W-1:0] sh_tog,
   output level_e           sh_pol,
   output logic [TOG_W-1:0] act_tog,
   output level_e           act_pol
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_tog <= '0;
         sh_pol <= LVL_LOW;
      end else if (wr_en) begin
         sh_tog <= wr_tog;
         sh_pol <= wr_pol;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_tog <= '0;
         act_pol <= LVL_LOW;
      end else if (load) begin
         act_tog <= sh_tog;
         act_pol <= sh_pol;
      end
   end
endmodule

// File: rtl/bpg_line_ctr.sv
module bpg_line_ctr
   import bpg_pkg::*;
#(
   parameter int TOG_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [TOG_W-1:0] cnt
);
   localparam logic [TOG_W-1:0] CNT_MAX = TOG_W'(ctr_max(TOG_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (step && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bias_pulse_gen.sv
module bias_pulse_gen
   import bpg_pkg::*;
#(
   parameter int   TOG_W       = 11,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vd_i,
   input  logic             hd_i,
   input  logic             wr_en_i,
   input  logic [TOG_W-1:0] wr_toggle_i,
   input  logic             wr_pol_i,
   output logic             bias_o
);
   generate
      if (TOG_W < 2 || TOG_W > 16) begin : g_bad_width
         $error("bias_pulse_gen: TOG_W must be within 2..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bias_pulse_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             vd_fall;
   logic             hd_fall;
   logic [TOG_W-1:0] line_cnt;
   logic [TOG_W-1:0] sh_tog;
   logic [TOG_W-1:0] act_tog;
   level_e           sh_pol;
   level_e           act_pol;

   bpg_edge_det #(.STAGES(SYNC_STAGES)) u_vd_edge (
      .clk(clk), .rst_n(rst_n), .din(vd_i), .fall_o(vd_fall)
   );

   bpg_edge_det #(.STAGES(SYNC_STAGES)) u_hd_edge (
      .clk(clk), .rst_n(rst_n), .din(hd_i), .fall_o(hd_fall)
   );

   bpg_frame_regs #(.TOG_W(TOG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_tog(wr_toggle_i), .wr_pol(level_e'(wr_pol_i)),
      .load(vd_fall),
      .sh_tog(sh_tog), .sh_pol(sh_pol),
      .act_tog(act_tog), .act_pol(act_pol)
   );

   // frame edge has priority over line edge inside the counter
   bpg_line_ctr #(.TOG_W(TOG_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(vd_fall), .step(hd_fall), .cnt(line_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               bias_o <= IDLE_LEVEL;
      else if (!vd_fall && line_cnt == act_tog) bias_o <= logic'(act_pol);
   end
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
   parameter int TOG_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vd_fall,
   input logic             hd_fall,
   input logic [TOG_W-1:0] cnt,
   input logic [TOG_W-1:0] sh_tog,
   input logic             sh_pol,
   input logic [TOG_W-1:0] act_tog,
   input logic             act_pol,
   input logic             bias
);
   localparam logic [TOG_W-1:0] CMAX = {TOG_W{1'b1}};

   p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vd_fall |=> cnt == '0);

   p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hd_fall && !vd_fall && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);

   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hd_fall && !vd_fall) |=> $stable(cnt));

   p_active_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !vd_fall |=> ($stable(act_tog) && $stable(act_pol)));

   p_active_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vd_fall |=> (act_tog == $past(sh_tog) && act_pol == $past(sh_pol)));

   p_out_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vd_fall && cnt == act_tog) |=> bias == $past(act_pol));

   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_fall || cnt != act_tog) |=> $stable(bias));
endmodule

bind bias_pulse_gen bpg_checker #(.TOG_W(TOG_W)) u_bpg_checker (
   .clk(clk), .rst_n(rst_n), .vd_fall(vd_fall), .hd_fall(hd_fall),
   .cnt(line_cnt), .sh_tog(sh_tog), .sh_pol(sh_pol),
   .act_tog(act_tog), .act_pol(act_pol), .bias(bias_o)
);

// File: tb/test_bias_pulse_gen.sv
`timescale 1ns/1ps
module test_bias_pulse_gen;
   localparam int TW  = 11;
   localparam int STG = 2;
   localparam int MAXC = (1 << TW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vd = 1'b1, hd = 1'b1, wr_en = 1'b0, wr_pol = 1'b0;
   logic [TW-1:0] wr_tog = '0;
   logic bias;

   int tests = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   bias_pulse_gen #(.TOG_W(TW), .SYNC_STAGES(STG)) i_bias_pulse_gen (
      .clk(clk), .rst_n(rst_n), .vd_i(vd), .hd_i(hd),
      .wr_en_i(wr_en), .wr_toggle_i(wr_tog), .wr_pol_i(wr_pol), .bias_o(bias)
   );

   // behavioural reference: pin history, then frame/line bookkeeping
   bit hv[$], hh[$];
   int m_cnt, m_sh_tog, m_act_tog;
   bit m_sh_pol, m_act_pol, m_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         hv = {}; hh = {};
         for (int i = 0; i < STG + 2; i++) begin hv.push_back(0); hh.push_back(0); end
         m_cnt = 0; m_sh_tog = 0; m_act_tog = 0; m_sh_pol = 0; m_act_pol = 0; m_out = 0;
      end else begin
         bit fv, fh, nout;
         int ncnt;
         hv.push_front(vd); void'(hv.pop_back());
         hh.push_front(hd); void'(hh.pop_back());
         fv = hv[STG+1] && !hv[STG];
         fh = hh[STG+1] && !hh[STG];
         nout = m_out;
         if (!fv && m_cnt == m_act_tog) nout = m_act_pol;
         ncnt = m_cnt;
         if (fv) ncnt = 0;
         else if (fh && m_cnt < MAXC) ncnt = m_cnt + 1;
         if (fv) begin m_act_tog = m_sh_tog; m_act_pol = m_sh_pol; end
         if (wr_en) begin m_sh_tog = wr_tog; m_sh_pol = wr_pol; end
         m_cnt = ncnt;
         m_out = nout;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (bias !== m_out) begin
            fails++;
            $display("FAIL %s model compare: actual=%b expected=%b @%0t", cur_req, bias, m_out, $time);
         end
      end
   end

   task automatic chk(input string req, input logic exp);
      tests++;
      if (bias !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b @%0t", req, bias, exp, $time);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_regs(input int t, input bit p);
      @(negedge clk);
      wr_en = 1'b1; wr_tog = TW'(t); wr_pol = p;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic vd_pulse();
      @(negedge clk); vd = 1'b0;
      wait_n(3); vd = 1'b1;
      wait_n(3);
   endtask

   task automatic hd_line();
      @(negedge clk); hd = 1'b0;
      wait_n(2); hd = 1'b1;
      wait_n(4);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) hd_line();
   endtask

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(1);
      cur_req = "R1";
      chk("R1", 1'b0);
      vd_pulse(); lines(4);
      chk("R1", 1'b0);

      cur_req = "R2";
      lines(1);
      write_regs(2, 1'b1);
      lines(4);
      chk("R2", 1'b0);

      cur_req = "R5";
      vd_pulse();
      chk("R3", 1'b0);
      lines(1);
      chk("R5", 1'b0);
      // R12: measure latency on the second line edge
      @(negedge clk); hd = 1'b0;
      wait_n(STG + 1);
      chk("R12", 1'b0);
      wait_n(1);
      chk("R12", 1'b1);
      chk("R5", 1'b1);
      hd = 1'b1; wait_n(4);
      lines(2);

      cur_req = "R6";
      write_regs(3, 1'b0);
      chk("R2", 1'b1);
      vd_pulse();
      chk("R7", 1'b1);
      lines(2);
      chk("R6", 1'b1);
      lines(1);
      chk("R6", 1'b0);
      lines(1);

      cur_req = "R9";
      write_regs(5, 1'b1);
      write_regs(1, 1'b1);
      write_regs(4, 1'b1);
      vd_pulse();
      lines(3);
      chk("R9", 1'b0);
      lines(1);
      chk("R9", 1'b1);
      lines(2);

      cur_req = "R10";
      write_regs(10, 1'b0);
      vd_pulse();
      lines(6);
      chk("R10", 1'b1);

      cur_req = "R8";
      write_regs(1, 1'b0);
      @(negedge clk); vd = 1'b0; hd = 1'b0;
      wait_n(3); vd = 1'b1; hd = 1'b1;
      wait_n(3);
      chk("R8", 1'b1);
      lines(1);
      chk("R8", 1'b0);

      cur_req = "R11";
      write_regs(0, 1'b1);
      vd_pulse();
      chk("R11", 1'b1);
      lines(2);
      chk("R11", 1'b1);

      cur_req = "R4";
      write_regs(7, 1'b0);
      vd_pulse();
      lines(6);
      chk("R4", 1'b1);
      lines(1);
      chk("R4", 1'b0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule